// File: doc/BRIEF.md
# Hexadecimal Seven-Segment Decoder with Zero Suppression

This block turns a 4-bit value into the seven segment drive lines of a common-anode display. Every code from 0 to F shows its own glyph, with lowercase forms for 0xB and 0xD so that they cannot be mistaken for 8 and 0. Both the segment lines and the control lines are active low.

Three control inputs are added for displays with several digits. A forced blank turns the digit dark. A lamp test lights every segment. A ripple-blanking input darkens the digit when its value is zero. A ripple-blanking output tells the next lower digit that every digit above it was dark. Chaining the output of each digit to the input of the digit below it suppresses leading zeros. The most significant digit has its ripple input tied low, and the least significant digit has its ripple input tied high so that a lone zero still shows. The block has no registers: the outputs follow the inputs directly.

Top module: `hex_seg_decoder`

## Requirements
- R1: With `blank_n`, `lamp_test_n` and `rb_in_n` all 1, `seg_n` is the bitwise inverse of the glyph for `digit`. Bit 0 of `seg_n` is segment a (top), bit 1 is b (upper right), bit 2 is c (lower right), bit 3 is d (bottom), bit 4 is e (lower left), bit 5 is f (upper left) and bit 6 is g (middle). The lit patterns, written as hexadecimal with bit 6 first, are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 b:7C C:39 d:5E E:79 F:71.
- R2: Under normal decoding the 16 codes give 16 different `seg_n` values, and each of them lights at least one segment (`seg_n` is never 7'h7F).
- R3: When `blank_n` is 0, `seg_n` is 7'h7F (all segments dark), whatever the values of `digit`, `lamp_test_n` and `rb_in_n`.
- R4: When `blank_n` is 1 and `lamp_test_n` is 0, `seg_n` is 7'h00 (all segments lit), whatever the values of `digit` and `rb_in_n`.
- R5: When `blank_n` and `lamp_test_n` are 1, `rb_in_n` is 0 and `digit` is 0, `seg_n` is 7'h7F.
- R6: When `rb_in_n` is 0 and `digit` is not zero, with `blank_n` and `lamp_test_n` at 1, `seg_n` is the normal glyph of R1.
- R7: `rb_out_n` is 0 exactly when `rb_in_n` is 0, `digit` is 0 and `lamp_test_n` is 1. In every other case it is 1, whatever the value of `blank_n`.
- R8: The outputs depend only on the present inputs. They settle without any clock edge, and they do not change while the inputs stay still.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| digit | input | 4 | Value to show. Bit 3 is the most significant bit. |
| lamp_test_n | input | 1 | Active-low lamp test. When 0, it lights all segments. |
| blank_n | input | 1 | Active-low forced blank. When 0, it darkens all segments. |
| rb_in_n | input | 1 | Active-low ripple-blanking input. When 0, a zero value is shown dark. |
| seg_n | output | 7 | Active-low segment lines. Bit 0 is segment a and bit 6 is segment g. |
| rb_out_n | output | 1 | Active-low ripple-blanking output, fed to the next lower digit. |

## Verification
The assertions check the priority of the controls whenever the inputs change. They check that a forced blank always darkens the digit, that a lamp test lights every segment when there is no blank, that a zero is dark under ripple blanking, and that the ripple output follows its rule. Whether each glyph has the right shape, and whether the 16 glyphs differ from one another, can be shown only by the bench. The bench compares all 16 values against its own table under all eight combinations of the controls, then runs a chain of digits that suppresses leading zeros.

// File: rtl/hex_seg_decoder.sv
module hex_seg_decoder #(
  parameter int SEGS = 7
) (
  input  logic [3:0]      digit,
  input  logic            lamp_test_n,
  input  logic            blank_n,
  input  logic            rb_in_n,
  output logic [SEGS-1:0] seg_n,
  output logic            rb_out_n
);

  localparam logic [SEGS-1:0] ALL_DARK = '1;
  localparam logic [SEGS-1:0] ALL_LIT  = '0;

  logic [SEGS-1:0] glyph;
  logic            is_zero;
  logic            zero_blank;

  always_comb begin
    unique case (digit)
      4'h0: glyph = 7'h3F;
      4'h1: glyph = 7'h06;
      4'h2: glyph = 7'h5B;
      4'h3: glyph = 7'h4F;
      4'h4: glyph = 7'h66;
      4'h5: glyph = 7'h6D;
      4'h6: glyph = 7'h7D;
      4'h7: glyph = 7'h07;
      4'h8: glyph = 7'h7F;
      4'h9: glyph = 7'h6F;
      4'hA: glyph = 7'h77;
      4'hB: glyph = 7'h7C;
      4'hC: glyph = 7'h39;
      4'hD: glyph = 7'h5E;
      4'hE: glyph = 7'h79;
      default: glyph = 7'h71;
    endcase
  end

  assign is_zero    = (digit == 4'h0);
  assign zero_blank = !rb_in_n && is_zero;

  assign seg_n = !blank_n     ? ALL_DARK :
                 !lamp_test_n ? ALL_LIT  :
                 zero_blank   ? ALL_DARK :
                                ~glyph;

  assign rb_out_n = !(zero_blank && lamp_test_n);

endmodule

// File: rtl/hex_seg_decoder_checker.sv
module hex_seg_decoder_checker #(
  parameter int SEGS = 7
) (
  input logic [3:0]      digit,
  input logic            lamp_test_n,
  input logic            blank_n,
  input logic            rb_in_n,
  input logic [SEGS-1:0] seg_n,
  input logic            rb_out_n
);

  logic known;
  assign known = !$isunknown({digit, lamp_test_n, blank_n, rb_in_n, seg_n, rb_out_n});

  always_comb begin
    if (known) begin
      if (!blank_n)
        assert_blank_dark_R3: assert (seg_n == '1);
      if (blank_n && !lamp_test_n)
        assert_lamp_lit_R4: assert (seg_n == '0);
      if (blank_n && lamp_test_n && !rb_in_n && digit == 4'h0)
        assert_zero_dark_R5: assert (seg_n == '1);
      if (blank_n && lamp_test_n && digit != 4'h0)
        assert_nonzero_shown_R2: assert (seg_n != '1);
      assert_ripple_out_R7: assert (rb_out_n == !(!rb_in_n && digit == 4'h0 && lamp_test_n));
    end
  end

endmodule

bind hex_seg_decoder hex_seg_decoder_checker #(.SEGS(SEGS)) u_chk (.*);

// File: tb/hex_seg_decoder_bench.sv
`timescale 1ns/1ps
module hex_seg_decoder_bench;

  localparam logic [6:0] GLYPH [16] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
    7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [3:0] digit;
  logic       lamp_test_n, blank_n, rb_in_n;
  logic [6:0] seg_n;
  logic       rb_out_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  hex_seg_decoder u_hex_seg_decoder (
    .digit(digit), .lamp_test_n(lamp_test_n), .blank_n(blank_n),
    .rb_in_n(rb_in_n), .seg_n(seg_n), .rb_out_n(rb_out_n)
  );

  logic [3:0] hi_d, lo_d;
  logic [6:0] hi_seg, lo_seg;
  logic       hi_rbo, lo_rbo;

  hex_seg_decoder u_hi (
    .digit(hi_d), .lamp_test_n(1'b1), .blank_n(1'b1), .rb_in_n(1'b0),
    .seg_n(hi_seg), .rb_out_n(hi_rbo)
  );
  hex_seg_decoder u_lo (
    .digit(lo_d), .lamp_test_n(1'b1), .blank_n(1'b1), .rb_in_n(hi_rbo),
    .seg_n(lo_seg), .rb_out_n(lo_rbo)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (digit %h lt %b bl %b rbi %b)",
               req, act, exp, digit, lamp_test_n, blank_n, rb_in_n);
    end
  endtask

  task automatic apply(input logic [3:0] d, input logic lt, input logic bl, input logic rbi);
    @(negedge clk);
    digit = d; lamp_test_n = lt; blank_n = bl; rb_in_n = rbi;
    #1;
  endtask

  initial begin
    digit = 4'h0; lamp_test_n = 1'b1; blank_n = 1'b1; rb_in_n = 1'b1;
    hi_d = 4'h0; lo_d = 4'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    check("R1 idle", {1'b0, seg_n}, {1'b0, ~GLYPH[0]});
    check("R7 idle", {7'b0, rb_out_n}, 8'h01);

    for (int v = 0; v < 16; v++) begin
      for (int c = 0; c < 8; c++) begin
        logic lt, bl, rbi;
        logic [6:0] exp_seg;
        logic exp_rbo;
        bl = c[2]; lt = c[1]; rbi = c[0];
        apply(v[3:0], lt, bl, rbi);
        if (!bl)                    exp_seg = 7'h7F;
        else if (!lt)               exp_seg = 7'h00;
        else if (!rbi && v == 0)    exp_seg = 7'h7F;
        else                        exp_seg = ~GLYPH[v];
        exp_rbo = !(!rbi && v == 0 && lt);
        if (!bl)                 check("R3 blank", {1'b0, seg_n}, {1'b0, exp_seg});
        else if (!lt)            check("R4 lamp", {1'b0, seg_n}, {1'b0, exp_seg});
        else if (!rbi && v == 0) check("R5 zero", {1'b0, seg_n}, {1'b0, exp_seg});
        else if (!rbi)           check("R6 nonzero", {1'b0, seg_n}, {1'b0, exp_seg});
        else                     check("R1 glyph", {1'b0, seg_n}, {1'b0, exp_seg});
        check("R7 ripple", {7'b0, rb_out_n}, {7'b0, exp_rbo});
      end
    end

    begin
      logic [6:0] seen [16];
      for (int v = 0; v < 16; v++) begin
        apply(v[3:0], 1'b1, 1'b1, 1'b1);
        seen[v] = seg_n;
        check("R2 lit", {7'b0, seg_n != 7'h7F}, 8'h01);
      end
      for (int i = 0; i < 16; i++)
        for (int j = i + 1; j < 16; j++)
          check("R2 distinct", {7'b0, seen[i] != seen[j]}, 8'h01);
    end

    apply(4'h8, 1'b1, 1'b1, 1'b1);
    check("R8 settle", {1'b0, seg_n}, {1'b0, ~GLYPH[8]});
    repeat (4) @(posedge clk);
    #1;
    check("R8 hold", {1'b0, seg_n}, {1'b0, ~GLYPH[8]});
    apply(4'h0, 1'b1, 1'b0, 1'b0);
    check("R7 blank ignored", {7'b0, rb_out_n}, 8'h00);

    @(negedge clk); hi_d = 4'h0; lo_d = 4'h0; #1;
    check("R5 chain hi", {1'b0, hi_seg}, 8'h7F);
    check("R7 chain lo", {1'b0, lo_seg}, 8'h7F);
    @(negedge clk); hi_d = 4'h0; lo_d = 4'h5; #1;
    check("R6 chain lo", {1'b0, lo_seg}, {1'b0, ~GLYPH[5]});
    check("R7 chain rbo", {7'b0, lo_rbo}, 8'h01);
    @(negedge clk); hi_d = 4'h3; lo_d = 4'h0; #1;
    check("R1 chain hi", {1'b0, hi_seg}, {1'b0, ~GLYPH[3]});
    check("R7 chain inner zero", {1'b0, lo_seg}, {1'b0, ~GLYPH[0]});

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule